// File: doc/BRIEF.md
# Two-Level External Interrupt Controller

This block gathers four interrupt sources into latched flags: three edge-triggered input pins and a change detector on the upper half of an 8-bit port. Each pin has its own choice of rising or falling edge. Each source has an enable bit. Each source is also routed to a high or a low request level. Pin 0 is always routed to the high level. The other three sources each have a priority bit.

A small synchronous register port lets software set up the controller. Through it, software programs the edge selects, enables, priorities and the two global enables, reads the flags, and clears flags by writing zero to them. Two request outputs go to the processor, one for each priority level. Both are gated by the global enable, and the low level is also gated by its own enable. A separate wake output is asserted whenever an enabled source has a pending flag, whatever the global enables say, so a sleeping core can be woken.

All pin and port inputs pass through a synchronizer before any edge or change is detected. The controller takes no part in vectoring or in saving context.

Top module: `xirq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register bit is 0, so all pins select falling edges. `irq_hi_o`, `irq_lo_o` and `wake_o` are 0, and reading any address returns 0. Address 3 always reads 0.
- R2: Register 1 bits 3:1 select the edge for pins 2, 1 and 0: 1 means rising, 0 means falling. A selected edge sets that pin's flag. Edges of the opposite polarity set nothing.
- R3: The flags sit at register 0 bit 1 (pin 0), register 0 bit 0 (port change), register 2 bit 0 (pin 1) and register 2 bit 1 (pin 2). A flag holds until software writes 0 to its bit. Writing 1 to a flag bit leaves it unchanged.
- R4: The enables sit in register 0: bit 2 for pin 0, bit 4 for pin 1, bit 5 for pin 2 and bit 3 for port change. A clear enable keeps its source out of every request and out of wake, but the flag still gets set.
- R5: Pin 0 always requests at the high level. Register 2 bit 6 (pin 1) and bit 7 (pin 2), and register 1 bit 0 (port change), select high when 1 and low when 0.
- R6: Any change on port bits 7:4 sets the port-change flag. Changes on port bits 3:0 have no effect.
- R7: `irq_hi_o` is 1 exactly when register 0 bit 7 (global enable) is 1 and some high-level source has both its flag and its enable set.
- R8: `irq_lo_o` is 1 exactly when register 0 bit 7 and register 0 bit 6 (low-level enable) are both 1 and some low-level source has both its flag and its enable set.
- R9: `wake_o` is 1 whenever any source has both its flag and its enable set, regardless of either global enable.
- R10: When a write clears a flag in the same cycle as a new event on that source, the flag stays set.
- R11: A pin transition that is applied before clock edge k becomes visible on the request outputs after edge k+2. It is not visible after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 3 | External interrupt pins 2..0 (asynchronous) |
| port_i | input | 8 | Port whose bits 7:4 are watched for change |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, one cycle after the address |
| irq_hi_o | output | 1 | High-priority interrupt request |
| irq_lo_o | output | 1 | Low-priority interrupt request |
| wake_o | output | 1 | Wake request, independent of the global enables |

## Verification
The vector walk tests each pin with both rising and falling selection. Opposite-polarity edges are applied to show that the polarity choice really filters events. Mixed selects on the three pins show that each pin is decoded separately.

Sources are then enabled one at a time and routed to each level in turn. The global and low-level enables are cleared one after the other, which separates the two request outputs from the wake path.

Port transitions confined to bits 3:0 are contrasted with transitions on bits 7:4. Directed sequences then pin down the synchronizer latency, flag persistence under writes of 1, and the case where a clear and a set land in the same cycle.

// File: rtl/xirq_pkg.sv
// Shared constants and types for the two-level external interrupt controller.
// Assumes a fixed set of four sources: three pins and one port-change source.
package xirq_pkg;
    localparam int NSRC    = 4;
    localparam int SRC_P0  = 0;
    localparam int SRC_P1  = 1;
    localparam int SRC_P2  = 2;
    localparam int SRC_CHG = 3;
    localparam int NPIN    = 3;
    localparam int REG_W   = 8;

    localparam logic [1:0] A_CTL0 = 2'd0;
    localparam logic [1:0] A_CTL1 = 2'd1;
    localparam logic [1:0] A_CTL2 = 2'd2;

    typedef struct packed {
        logic            gie;
        logic            gie_lo;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] hi_pri;
        logic [NPIN-1:0] rise_sel;
    } xirq_cfg_t;
endpackage

// File: rtl/xirq_sync.sv
// Multi-stage synchronizer for asynchronous inputs.
// Assumes STAGES >= 1; every stage resets to 0 synchronously.
module xirq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // capture the raw asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d_i;
            end
        end else begin : g_next
            // shift through the following stages
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/xirq_detect.sv
// Per-bit event detector on already-synchronized signals.
// CHANGE=0: a selectable edge per bit (rise_sel_i=1 rising, 0 falling).
// CHANGE=1: any transition; rise_sel_i is ignored.
module xirq_detect #(
    parameter int W      = 1,
    parameter bit CHANGE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    input  logic [W-1:0] rise_sel_i,
    output logic [W-1:0] ev_o
);
    logic [W-1:0] prev_q;

    // hold the previous-cycle value for comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig_i;
    end

    if (CHANGE) begin : g_change
        logic unused_sel;
        assign unused_sel = ^rise_sel_i;
        assign ev_o = sig_i ^ prev_q;
    end else begin : g_edge
        for (genvar b = 0; b < W; b++) begin : g_bit
            assign ev_o[b] = rise_sel_i[b] ? (sig_i[b] & ~prev_q[b])
                                           : (~sig_i[b] & prev_q[b]);
        end
    end
endmodule

// File: rtl/xirq_regs.sv
// Control registers and latched flags.
// Reg0: [7] global en, [6] low-level en, [5] pin2 en, [4] pin1 en,
//       [3] change en, [2] pin0 en, [1] pin0 flag, [0] change flag.
// Reg1: [3:1] edge select pins 2..0, [0] change priority.
// Reg2: [7] pin2 priority, [6] pin1 priority, [1] pin2 flag, [0] pin1 flag.
// Flags clear on a written 0; a concurrent event wins.
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [NSRC-1:0]   ev_i,
    output logic [NSRC-1:0]   flag_o,
    output xirq_cfg_t         cfg_o,
    output logic [REG_W-1:0]  rdata_o
);
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] keep;
    logic [NSRC-1:0] en_q;
    logic [NPIN-1:0] rise_q;
    logic            gie_q, gie_lo_q;
    logic            pri1_q, pri2_q, pri_chg_q;
    logic [REG_W-1:0] rd_mux;
    logic            wr0, wr1, wr2;

    assign wr0 = wr_en_i && (addr_i == ADDR_W'(A_CTL0));
    assign wr1 = wr_en_i && (addr_i == ADDR_W'(A_CTL1));
    assign wr2 = wr_en_i && (addr_i == ADDR_W'(A_CTL2));

    // decide which flags survive this cycle's write
    always_comb begin
        keep = '1;
        if (wr0) begin
            keep[SRC_P0]  = wdata_i[1];
            keep[SRC_CHG] = wdata_i[0];
        end
        if (wr2) begin
            keep[SRC_P1] = wdata_i[0];
            keep[SRC_P2] = wdata_i[1];
        end
    end

    // latch flags: events set, written zeros clear, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & keep) | ev_i;
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q     <= 1'b0;
            gie_lo_q  <= 1'b0;
            en_q      <= '0;
            rise_q    <= '0;
            pri1_q    <= 1'b0;
            pri2_q    <= 1'b0;
            pri_chg_q <= 1'b0;
        end else begin
            if (wr0) begin
                gie_q         <= wdata_i[7];
                gie_lo_q      <= wdata_i[6];
                en_q[SRC_P2]  <= wdata_i[5];
                en_q[SRC_P1]  <= wdata_i[4];
                en_q[SRC_CHG] <= wdata_i[3];
                en_q[SRC_P0]  <= wdata_i[2];
            end
            if (wr1) begin
                rise_q    <= wdata_i[3:1];
                pri_chg_q <= wdata_i[0];
            end
            if (wr2) begin
                pri2_q <= wdata_i[7];
                pri1_q <= wdata_i[6];
            end
        end
    end

    // select the register image for the read port
    always_comb begin
        case (addr_i)
            ADDR_W'(A_CTL0): rd_mux = {gie_q, gie_lo_q, en_q[SRC_P2], en_q[SRC_P1],
                                       en_q[SRC_CHG], en_q[SRC_P0],
                                       flag_q[SRC_P0], flag_q[SRC_CHG]};
            ADDR_W'(A_CTL1): rd_mux = {4'b0, rise_q, pri_chg_q};
            ADDR_W'(A_CTL2): rd_mux = {pri2_q, pri1_q, 4'b0,
                                       flag_q[SRC_P2], flag_q[SRC_P1]};
            default:         rd_mux = '0;
        endcase
    end

    // register the read data
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_o <= '0;
        else        rdata_o <= rd_mux;
    end

    assign flag_o          = flag_q;
    assign cfg_o.gie       = gie_q;
    assign cfg_o.gie_lo    = gie_lo_q;
    assign cfg_o.en        = en_q;
    assign cfg_o.hi_pri    = {pri_chg_q, pri2_q, pri1_q, 1'b1};
    assign cfg_o.rise_sel  = rise_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // R3
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !wr_en_i) |=> flag_q[i]);
        // R10
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[i] |=> flag_q[i]);
        // R2
        no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_q[i] && !ev_i[i]) |=> !flag_q[i]);
    end
endmodule

// File: rtl/xirq_req.sv
// Combines flags, enables and priority routing into the two request levels
// and the wake request. Purely combinational.
module xirq_req
    import xirq_pkg::*;
(
    input  logic [NSRC-1:0] flag_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] hi_pri_i,
    input  logic            gie_i,
    input  logic            gie_lo_i,
    output logic            irq_hi_o,
    output logic            irq_lo_o,
    output logic            wake_o
);
    logic [NSRC-1:0] pend;

    // pending = flagged and enabled; split by level, gate by global enables
    always_comb begin
        pend     = flag_i & en_i;
        irq_hi_o = gie_i & |(pend & hi_pri_i);
        irq_lo_o = gie_i & gie_lo_i & |(pend & ~hi_pri_i);
        wake_o   = |pend;
    end
endmodule

// File: rtl/xirq_ctrl.sv
// Two-level external interrupt controller top.
// Assumes pins and port are asynchronous and need SYNC_STAGES flops.
// Only port bits PORT_W-1:CHG_LSB take part in change detection.
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int CHG_LSB     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_hi_o,
    output logic              irq_lo_o,
    output logic              wake_o
);
    localparam int CHG_W = PORT_W - CHG_LSB;

    logic [NPIN-1:0]  pin_s, pin_ev;
    logic [CHG_W-1:0] chg_s, chg_ev;
    logic [NSRC-1:0]  src_ev, flags;
    xirq_cfg_t        cfg;
    logic             unused_port;

    assign unused_port = ^port_i[CHG_LSB-1:0];

    xirq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s));

    xirq_sync #(.W(CHG_W), .STAGES(SYNC_STAGES)) u_port_sync (
        .clk(clk), .rst_n(rst_n), .d_i(port_i[PORT_W-1:CHG_LSB]), .q_o(chg_s));

    xirq_detect #(.W(NPIN), .CHANGE(1'b0)) u_pin_det (
        .clk(clk), .rst_n(rst_n), .sig_i(pin_s),
        .rise_sel_i(cfg.rise_sel), .ev_o(pin_ev));

    xirq_detect #(.W(CHG_W), .CHANGE(1'b1)) u_port_det (
        .clk(clk), .rst_n(rst_n), .sig_i(chg_s),
        .rise_sel_i('0), .ev_o(chg_ev));

    assign src_ev = {|chg_ev, pin_ev};

    xirq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .ev_i(src_ev), .flag_o(flags),
        .cfg_o(cfg), .rdata_o(rdata_o));

    xirq_req u_req (
        .flag_i(flags), .en_i(cfg.en), .hi_pri_i(cfg.hi_pri),
        .gie_i(cfg.gie), .gie_lo_i(cfg.gie_lo),
        .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o), .wake_o(wake_o));

    // R7
    hi_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi_o |-> cfg.gie);
    // R8
    lo_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo_o |-> (cfg.gie && cfg.gie_lo));
    // R9
    wake_covers_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi_o || irq_lo_o) |-> wake_o);
    // R5
    p0_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[SRC_P0] && cfg.en[SRC_P0] && cfg.gie) |-> irq_hi_o);
    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en == '0) |-> (!wake_o && !irq_hi_o && !irq_lo_o));
endmodule

// File: tb/tb_xirq_ctrl.sv
module tb_xirq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pin = '0;
    logic [7:0] port = '0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_hi, irq_lo, wake;
    int         nchk = 0;
    int         nbad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    xirq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .port_i(port),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_hi_o(irq_hi), .irq_lo_o(irq_lo), .wake_o(wake));

    typedef struct packed {
        logic [2:0] sel;  // rising select per pin
        logic [3:0] en;   // {chg,p2,p1,p0}
        logic [2:0] hp;   // high priority {chg,p2,p1}
        logic       gie;
        logic       giel;
        logic [2:0] pf;
        logic [2:0] pt;
        logic [7:0] qf;
        logic [7:0] qt;
        logic [3:0] xf;   // expected flags {chg,p2,p1,p0}
        logic       xhi;
        logic       xlo;
        logic       xwk;
    } vec_t;

    // R2 polarity, R4 enables, R5 routing, R6 port nibble, R7/R8/R9 outputs
    localparam vec_t VT [12] = '{
        '{3'b111, 4'b1111, 3'b000, 1'b1, 1'b1, 3'b000, 3'b001, 8'h00, 8'h00, 4'b0001, 1'b1, 1'b0, 1'b1},
        '{3'b000, 4'b1111, 3'b011, 1'b1, 1'b1, 3'b111, 3'b001, 8'h00, 8'h00, 4'b0110, 1'b1, 1'b0, 1'b1},
        '{3'b111, 4'b1111, 3'b000, 1'b1, 1'b1, 3'b111, 3'b000, 8'h00, 8'h00, 4'b0000, 1'b0, 1'b0, 1'b0},
        '{3'b010, 4'b0001, 3'b000, 1'b1, 1'b1, 3'b101, 3'b010, 8'h00, 8'h00, 4'b0111, 1'b1, 1'b0, 1'b1},
        '{3'b111, 4'b0010, 3'b000, 1'b1, 1'b1, 3'b000, 3'b010, 8'h00, 8'h00, 4'b0010, 1'b0, 1'b1, 1'b1},
        '{3'b111, 4'b0010, 3'b000, 1'b1, 1'b0, 3'b000, 3'b010, 8'h00, 8'h00, 4'b0010, 1'b0, 1'b0, 1'b1},
        '{3'b111, 4'b0010, 3'b000, 1'b0, 1'b1, 3'b000, 3'b010, 8'h00, 8'h00, 4'b0010, 1'b0, 1'b0, 1'b1},
        '{3'b000, 4'b1000, 3'b100, 1'b1, 1'b0, 3'b000, 3'b000, 8'h00, 8'h10, 4'b1000, 1'b1, 1'b0, 1'b1},
        '{3'b000, 4'b1111, 3'b000, 1'b1, 1'b1, 3'b000, 3'b000, 8'h00, 8'h0F, 4'b0000, 1'b0, 1'b0, 1'b0},
        '{3'b000, 4'b1000, 3'b000, 1'b1, 1'b1, 3'b000, 3'b000, 8'hF0, 8'h00, 4'b1000, 1'b0, 1'b1, 1'b1},
        '{3'b111, 4'b0000, 3'b000, 1'b1, 1'b1, 3'b000, 3'b111, 8'h00, 8'h00, 4'b0111, 1'b0, 1'b0, 1'b0},
        '{3'b100, 4'b0100, 3'b010, 1'b1, 1'b0, 3'b000, 3'b100, 8'h00, 8'h00, 4'b0100, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic drive(input logic [2:0] p, input logic [7:0] q, input int cyc);
        @(negedge clk);
        pin = p; port = q;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic read_flags(output logic [3:0] f);
        logic [7:0] r0, r2;
        rd(2'd0, r0);
        rd(2'd2, r2);
        f = {r0[0], r2[1], r2[0], r0[1]};
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        logic [3:0] f;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 irq_hi", {7'b0, irq_hi}, 8'h0);
        chk("R1 irq_lo", {7'b0, irq_lo}, 8'h0);
        chk("R1 wake", {7'b0, wake}, 8'h0);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk("R1 register", d, 8'h00);
        end

        // vector walk
        for (int v = 0; v < 12; v++) begin
            drive(VT[v].pf, VT[v].qf, 5);
            wr(2'd1, {4'b0, VT[v].sel, VT[v].hp[2]});
            wr(2'd2, {VT[v].hp[1], VT[v].hp[0], 6'b0});
            wr(2'd0, {VT[v].gie, VT[v].giel, VT[v].en[2], VT[v].en[1],
                      VT[v].en[3], VT[v].en[0], 2'b00});
            drive(VT[v].pt, VT[v].qt, 4);
            chk("R7 irq_hi", {7'b0, irq_hi}, {7'b0, VT[v].xhi});
            chk("R8 irq_lo", {7'b0, irq_lo}, {7'b0, VT[v].xlo});
            chk("R9 wake", {7'b0, wake}, {7'b0, VT[v].xwk});
            read_flags(f);
            chk("R2/R6 flags", {4'b0, f}, {4'b0, VT[v].xf});
        end

        // R11 latency: pin0 rising, high level
        wr(2'd2, 8'h00);
        wr(2'd1, 8'b0000_0010);
        drive(3'b000, 8'h00, 5);
        wr(2'd0, 8'b1000_0100);
        @(negedge clk);
        pin = 3'b001;
        repeat (2) @(negedge clk);
        chk("R11 not yet after two edges", {7'b0, irq_hi}, 8'h0);
        @(negedge clk);
        chk("R11 visible after third edge", {7'b0, irq_hi}, 8'h1);

        // R3 persistence and writing 1 to a flag
        wr(2'd0, 8'b1000_0111);
        chk("R3 write 1 keeps flag", {7'b0, irq_hi}, 8'h1);
        repeat (10) @(negedge clk);
        rd(2'd0, d);
        chk("R3 flag holds", {7'b0, d[1]}, 8'h1);
        wr(2'd0, 8'b1000_0100);
        chk("R3 write 0 clears", {7'b0, irq_hi}, 8'h0);

        // R10 set wins over simultaneous clear
        drive(3'b000, 8'h00, 4);
        drive(3'b001, 8'h00, 4);
        chk("R10 flag armed", {7'b0, irq_hi}, 8'h1);
        drive(3'b000, 8'h00, 4);
        @(negedge clk);
        pin = 3'b001;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; addr = 2'd0; wdata = 8'b1000_0100;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 set wins", {7'b0, irq_hi}, 8'h1);
        wr(2'd0, 8'b1000_0100);
        chk("R10 later clear works", {7'b0, irq_hi}, 8'h0);

        // R6 low nibble ignored while change source enabled
        wr(2'd0, 8'b1100_1000);
        drive(3'b001, 8'h05, 4);
        drive(3'b001, 8'h0A, 4);
        chk("R6 low nibble no wake", {7'b0, wake}, 8'h0);
        rd(2'd0, d);
        chk("R6 low nibble no flag", {7'b0, d[0]}, 8'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule